// File: doc/BRIEF.md
# Per-Lane Saturating Narrowing Pack

This block narrows two wide source vectors of signed 32-bit elements into one result vector of signed 16-bit elements. Each element is clamped to the signed 16-bit range, and a flag bit per result element records where clamping happened. The result is built lane by lane. Each 128-bit lane of the result holds the four narrowed A elements of that lane, followed by the four narrowed B elements of the same lane. No element moves between lanes.

A mode input picks one of two variants. The first packs both lanes. The second packs only the low lane and forces the upper half of the result and its flags to zero. A parameter picks between a purely combinational path and a single output register. The register loads whenever `in_valid` is high, and its `out_valid` follows one cycle later.

The output register's valid tracking is a two-state machine.
- `OUT_EMPTY` is the reset state. It moves to `OUT_FULL` when `in_valid` is high, and otherwise stays in `OUT_EMPTY`.
- `OUT_FULL` stays in `OUT_FULL` while `in_valid` stays high. It returns to `OUT_EMPTY` when `in_valid` is low.
- `out_valid` is high exactly in `OUT_FULL`.

Top module: `lane_pack_unit`

## Requirements
- R1: A source element in the range -32768..32767 appears unchanged in the low 16 bits of its result element, and its flag stays 0. This includes the two end values.
- R2: A source element above 32767 gives 16'h7FFF and sets its flag.
- R3: A source element below -32768 gives 16'h8000 and sets its flag.
- R4: With `mode`=0 (both lanes), result element k sits at bits [16k+15:16k]. Elements 0-3 come from A elements 0-3, and elements 4-7 come from B elements 0-3. Elements 8-11 come from A elements 4-7, and elements 12-15 come from B elements 4-7. Source element i sits at bits [32i+31:32i].
- R5: The two lanes are independent: changing the high 128 bits of A or B never changes result bits [127:0] or flags [7:0].
- R6: With `mode`=1 (low lane only), result elements 0-7 follow R4, while result bits [255:128] and flags [15:8] are 0.
- R7: Flag bit k belongs to result element k alone.
- R8: With the output register present, the result loaded from an input with `in_valid` high appears on the following cycle with `out_valid` high.
- R9: While `in_valid` is low, `out_valid` is 0 on the next cycle and `result` and `sat_flags` keep their last values.
- R10: After reset, `out_valid`, `result` and `sat_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load enable for the sources |
| mode | input | 1 | 0 = both lanes, 1 = low lane only |
| src_a | input | 256 | Eight signed 32-bit elements, first source |
| src_b | input | 256 | Eight signed 32-bit elements, second source |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Sixteen signed 16-bit elements |
| sat_flags | output | 16 | Clamp flag per result element |

## Verification
The bench builds the block with its default parameters: 32-bit sources, 16-bit results, two 128-bit lanes and the output register present. With the register present, the one-cycle latency, back-to-back loads and the hold during idle cycles are all observable at the ports. The two-lane default lets the bench change one lane's inputs and confirm that the other lane's result stays put. A sweep places a single clamped element at every result position, which exposes any mix-up of flags or element slots.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;

    typedef enum logic {
        PACK_BOTH_LANES = 1'b0,
        PACK_LOW_LANE   = 1'b1
    } pack_mode_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
    parameter int SRC_W = 32,
    parameter int DST_W = 16
) (
    input  logic [SRC_W-1:0] din,
    output logic [DST_W-1:0] dout,
    output logic             clamped
);
    localparam int HEAD_W = SRC_W - DST_W + 1;

    logic [HEAD_W-1:0] head;
    logic              fits;

    // the value fits when every bit above the target sign bit copies the sign
    assign head    = din[SRC_W-1:DST_W-1];
    assign fits    = (&head) | ~(|head);
    assign clamped = ~fits;
    assign dout    = fits ? din[DST_W-1:0]
                          : {din[SRC_W-1], {(DST_W-1){~din[SRC_W-1]}}};
endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
    parameter int SRC_W  = 32,
    parameter int DST_W  = 16,
    parameter int LANE_W = 128
) (
    input  logic [LANE_W-1:0]                           lane_a,
    input  logic [LANE_W-1:0]                           lane_b,
    output logic [2*(LANE_W/SRC_W)*DST_W-1:0]           lane_res,
    output logic [2*(LANE_W/SRC_W)-1:0]                 lane_sat
);
    localparam int PER_SRC = LANE_W / SRC_W;

    // A elements fill the low half of the lane, B elements the high half
    for (genvar e = 0; e < PER_SRC; e++) begin : g_elem
        sat_narrow #(.SRC_W(SRC_W), .DST_W(DST_W)) u_sat_a (
            .din     (lane_a[e*SRC_W +: SRC_W]),
            .dout    (lane_res[e*DST_W +: DST_W]),
            .clamped (lane_sat[e])
        );
        sat_narrow #(.SRC_W(SRC_W), .DST_W(DST_W)) u_sat_b (
            .din     (lane_b[e*SRC_W +: SRC_W]),
            .dout    (lane_res[(PER_SRC+e)*DST_W +: DST_W]),
            .clamped (lane_sat[PER_SRC+e])
        );
    end
endmodule

// File: rtl/lane_pack_unit.sv
module lane_pack_unit #(
    parameter int SRC_W     = 32,
    parameter int DST_W     = 16,
    parameter int LANE_W    = 128,
    parameter int NUM_LANES = 2,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            in_valid,
    input  logic                                            mode,
    input  logic [LANE_W*NUM_LANES-1:0]                     src_a,
    input  logic [LANE_W*NUM_LANES-1:0]                     src_b,
    output logic                                            out_valid,
    output logic [NUM_LANES*2*(LANE_W/SRC_W)*DST_W-1:0]     result,
    output logic [NUM_LANES*2*(LANE_W/SRC_W)-1:0]           sat_flags
);
    import lane_pack_pkg::*;

    localparam int LANE_ELEMS = 2 * (LANE_W / SRC_W);
    localparam int LANE_OUT_W = LANE_ELEMS * DST_W;
    localparam int RES_W      = NUM_LANES * LANE_OUT_W;
    localparam int FLAG_W     = NUM_LANES * LANE_ELEMS;

    pack_mode_e        pack_mode;
    logic [RES_W-1:0]  packed_res;
    logic [FLAG_W-1:0] packed_sat;

    assign pack_mode = pack_mode_e'(mode);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_OUT_W-1:0] l_res;
        logic [LANE_ELEMS-1:0] l_sat;

        lane_pack #(.SRC_W(SRC_W), .DST_W(DST_W), .LANE_W(LANE_W)) u_lane (
            .lane_a   (src_a[l*LANE_W +: LANE_W]),
            .lane_b   (src_b[l*LANE_W +: LANE_W]),
            .lane_res (l_res),
            .lane_sat (l_sat)
        );

        if (l == 0) begin : g_low
            assign packed_res[0 +: LANE_OUT_W] = l_res;
            assign packed_sat[0 +: LANE_ELEMS] = l_sat;
        end else begin : g_upper
            logic active;
            assign active = (pack_mode == PACK_BOTH_LANES);
            assign packed_res[l*LANE_OUT_W +: LANE_OUT_W] = active ? l_res : '0;
            assign packed_sat[l*LANE_ELEMS +: LANE_ELEMS] = active ? l_sat : '0;
        end
    end

    if (REG_OUT) begin : g_reg
        out_state_e        state_q, state_d;
        logic [RES_W-1:0]  res_q;
        logic [FLAG_W-1:0] sat_q;

        // next-state decode
        always_comb begin
            state_d = state_q;
            unique case (state_q)
                OUT_EMPTY: if (in_valid)  state_d = OUT_FULL;
                OUT_FULL:  if (!in_valid) state_d = OUT_EMPTY;
                default:   state_d = OUT_EMPTY;
            endcase
        end

        // state register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= OUT_EMPTY;
            else        state_q <= state_d;
        end

        // data register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                sat_q <= '0;
            end else if (in_valid) begin
                res_q <= packed_res;
                sat_q <= packed_sat;
            end
        end

        assign out_valid = (state_q == OUT_FULL);
        assign result    = res_q;
        assign sat_flags = sat_q;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = packed_res;
        assign sat_flags = packed_sat;
    end
endmodule

// File: rtl/lane_pack_unit_chk.sv
module lane_pack_unit_chk #(
    parameter int SRC_W  = 32,
    parameter int DST_W  = 16,
    parameter int RES_W  = 256,
    parameter int FLAG_W = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [SRC_W-1:0]  a0,
    input logic              out_valid,
    input logic [RES_W-1:0]  result,
    input logic [FLAG_W-1:0] sat_flags
);
    localparam logic [DST_W-1:0] POS_MAX = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] NEG_MIN = {1'b1, {(DST_W-1){1'b0}}};
    localparam int HALF_R = RES_W / 2;
    localparam int HALF_F = FLAG_W / 2;

    logic a0_high, a0_low;
    assign a0_high = !a0[SRC_W-1] && (|a0[SRC_W-2:DST_W-1]);
    assign a0_low  =  a0[SRC_W-1] && !(&a0[SRC_W-2:DST_W-1]);

    for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
        AST_FLAG_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
            sat_flags[k] |-> (result[k*DST_W +: DST_W] == POS_MAX ||
                              result[k*DST_W +: DST_W] == NEG_MIN)); // R7
    end

    if (REG_OUT) begin : g_seq
        AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flags))); // R9
        AST_LOW_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode) |=> (result[RES_W-1:HALF_R] == '0 &&
                                    sat_flags[FLAG_W-1:HALF_F] == '0)); // R6
        AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && a0_high) |=> (result[DST_W-1:0] == POS_MAX && sat_flags[0])); // R2
        AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && a0_low) |=> (result[DST_W-1:0] == NEG_MIN && sat_flags[0])); // R3
    end
endmodule

bind lane_pack_unit lane_pack_unit_chk #(
    .SRC_W  (SRC_W),
    .DST_W  (DST_W),
    .RES_W  (RES_W),
    .FLAG_W (FLAG_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .a0        (src_a[SRC_W-1:0]),
    .out_valid (out_valid),
    .result    (result),
    .sat_flags (sat_flags)
);

// File: tb/lane_pack_unit_tb.sv
module lane_pack_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         out_valid;
    logic [255:0] result;
    logic [15:0]  sat_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [255:0] res;
        logic [15:0]  flg;
        string        tag;
    } item_t;

    item_t exp_q[$];
    item_t last_item;

    always #10 clk = ~clk;  // 50 MHz

    lane_pack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result(result), .sat_flags(sat_flags)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic void sat_ref(input logic [31:0] v, output logic [15:0] o,
                                    output logic f);
        int signed s;
        s = signed'(v);
        if (s > 32767)       begin o = 16'h7FFF; f = 1'b1; end
        else if (s < -32768) begin o = 16'h8000; f = 1'b1; end
        else                 begin o = v[15:0];  f = 1'b0; end
    endfunction

    // element k of the result: lane k/8, A when (k%8)<4 else B, index lane*4 + k%4
    function automatic item_t expect_of(input logic m, input logic [255:0] a,
                                        input logic [255:0] b, input string tag);
        item_t it;
        it.res = '0; it.flg = '0; it.tag = tag;
        for (int k = 0; k < 16; k++) begin
            int lane = k / 8;
            int idx  = lane * 4 + (k % 4);
            logic [31:0] s;
            logic [15:0] o;
            logic f;
            if (!(m && lane == 1)) begin
                s = ((k % 8) < 4) ? a[idx*32 +: 32] : b[idx*32 +: 32];
                sat_ref(s, o, f);
                it.res[k*16 +: 16] = o;
                it.flg[k] = f;
            end
        end
        return it;
    endfunction

    task automatic drive(input logic m, input logic [255:0] a,
                         input logic [255:0] b, input string tag);
        @(negedge clk);
        mode = m; src_a = a; src_b = b; in_valid = 1'b1;
        exp_q.push_back(expect_of(m, a, b, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = {8{32'h7FFF_FFFF}};
            src_b = {8{32'h8000_0000}};
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected out_valid", 256'(out_valid), 256'(0));
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(result === it.res, it.tag, "result", result, it.res);
                    check(sat_flags === it.flg, it.tag, "flags", 256'(sat_flags), 256'(it.flg));
                    last_item = it;
                end
            end
        end
    end

    function automatic logic [255:0] pack8(input int signed v[8]);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = v[i];
        return r;
    endfunction

    initial begin
        int signed av[8];
        int signed bv[8];
        logic [255:0] a, b, lowref;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid === 1'b0 && result === '0 && sat_flags === '0, "R10",
              "reset state", result, '0);
        rst_n = 1'b1;

        // R1: in-range values including both end points
        av = '{32767, -32768, 0, 1, -1, 1234, -1234, 100};
        bv = '{-32767, 32766, 7, -7, 30000, -30000, 32767, -32768};
        drive(1'b0, pack8(av), pack8(bv), "R1");

        // R2: above range
        av = '{32768, 32'h7FFF_FFFF, 100000, 65535, 32768, 40000, 1<<20, 32767};
        drive(1'b0, pack8(av), pack8(av), "R2");

        // R3: below range
        bv = '{-32769, 32'h8000_0000, -100000, -65536, -32769, -40000, -(1<<20), -32768};
        drive(1'b0, pack8(bv), pack8(bv), "R3");

        // R4: ordering with distinct tags per element
        av = '{1, 2, 3, 4, 5, 6, 7, 8};
        bv = '{101, 102, 103, 104, 105, 106, 107, 108};
        drive(1'b0, pack8(av), pack8(bv), "R4");

        // R8: back-to-back loads already exercised; now idle and check hold (R9)
        idle(1);
        @(negedge clk);
        lowref = result;
        idle(3);
        @(negedge clk);
        check(out_valid === 1'b0, "R9", "out_valid during idle", 256'(out_valid), 256'(0));
        check(result === last_item.res, "R9", "result held", result, last_item.res);
        check(sat_flags === last_item.flg, "R9", "flags held",
              256'(sat_flags), 256'(last_item.flg));

        // R5: change only high halves; low half must match
        a = pack8(av); b = pack8(bv);
        drive(1'b0, a, b, "R5");
        a[255:128] = {4{32'h7000_0000}};
        b[255:128] = {4{32'h9000_0000}};
        drive(1'b0, a, b, "R5");
        idle(1);
        @(negedge clk);
        check(result[127:0] === lowref[127:0] && sat_flags[7:0] === 8'h00, "R5",
              "low lane unchanged", result, lowref);

        // R6: low-lane-only mode with saturating upper inputs
        drive(1'b1, a, b, "R6");
        drive(1'b1, pack8(av), pack8(bv), "R6");

        // R7: single clamped element walked through every position
        for (int k = 0; k < 16; k++) begin
            int lane = k / 8;
            int idx  = lane * 4 + (k % 4);
            a = '0; b = '0;
            if ((k % 8) < 4) a[idx*32 +: 32] = 32'h0001_0000;
            else             b[idx*32 +: 32] = 32'hFFFE_0000;
            drive(1'b0, a, b, "R7");
        end
        idle(2);
        check(exp_q.size() == 0, "R8", "all loads produced", 256'(exp_q.size()), '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule